// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block sits beside a DRAM command scheduler and answers one question each cycle: how long must the presented command wait before it may go out on the command bus without breaking a device timing rule? The scheduler places a command code with a rank and bank on the query inputs. One clock later it reads back a remaining-cycle count, a ready flag and an error flag for unknown codes. Whenever the scheduler actually issues a command, it pulses the insert strobe with that command's code, rank and bank.

Internally a free-running cycle counter stamps every issued command into slots kept per bank, per rank and for the whole channel. Every slot carries a valid bit, so a slot that was never written places no limit. Each rule is a minimum spacing from an earlier command. Several spacings come from the burst length and the read and write latencies, such as write latency plus burst length minus one plus write-to-read turnaround. A per-rank window holding the most recent ACT_WIN activates limits activate bursts. An insert is visible to a query made in the same cycle. All timing values are clock counts fixed at elaboration.

Top module: `dram_cmd_timing_chk`

## Requirements
- R1: After reset every slot counts as never used, so each legal query reports a wait of 0 and ready high. Command codes are ACT=0, RD=1, RDA=2, WR=3, WRA=4, PRE=5, PREA=6 and REFA=7.
- R2: An ACT to a bank waits T_RC after the last ACT to that bank. It waits T_RP after the last PRE to that bank, and T_RP after the last PREA to its rank.
- R3: An ACT to a bank waits BL+T_RP after an RDA to that bank, and WL+BL-1+T_WR+T_RP after a WRA to that bank.
- R4: Once a rank has had ACT_WIN activates, a new ACT to that rank waits until T_TAW cycles after the oldest of its last ACT_WIN activates.
- R5: An RD or RDA, to any rank, waits BL after the latest RD or RDA to any rank, and WL+BL-1+T_WTR after the latest WR or WRA to any rank.
- R6: A WR or WRA, to any rank, waits RL+BL+1 after the latest RD or RDA to any rank, and BL after the latest WR or WRA to any rank.
- R7: A PRE waits BL after the last RD to that bank and WL+BL-1+T_WR after the last WR to that bank.
- R8: A PREA waits T_RAS after the last ACT in its rank, BL after the last RD or RDA in its rank, and WL+BL-1+T_WR after the last WR or WRA in its rank.
- R9: A REFA waits, within its rank, T_RC after an ACT, BL+T_RP after an RDA, WL+BL-1+T_WR+T_RP after a WRA, T_RP after a PRE or PREA, and T_RFC after a REFA.
- R10: Every legal command waits at least 1 cycle after the last legal command inserted on any rank. An insert in the same cycle as the query counts as elapsed time 0.
- R11: The outputs are registered and reflect the query of the previous cycle. The wait is the largest remaining spacing, saturated at 2^WAIT_W-1. Ready is high exactly when the wait is 0 and the code is legal. With no insert and an unchanged query, a nonzero wait below saturation falls by one per cycle.
- R12: A query code of 8 to 15 gives err=1, ready=0 and wait=0 one cycle later. An insert with such a code records nothing and does not occupy the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qry_cmd | input | 4 | Command code being asked about |
| qry_rank | input | RANK_BITS | Rank of the queried command |
| qry_bank | input | BANK_BITS | Bank of the queried command |
| ins_valid | input | 1 | A command is issued this cycle |
| ins_cmd | input | 4 | Code of the issued command |
| ins_rank | input | RANK_BITS | Rank of the issued command |
| ins_bank | input | BANK_BITS | Bank of the issued command |
| wait_cnt | output | WAIT_W | Remaining cycles, saturating |
| cmd_ready | output | 1 | Queried command may issue now |
| cmd_err | output | 1 | Queried code is illegal |

## Verification
The hardest case to reach is a full activate window whose oldest entry, and not any bank's own T_RC, sets the wait. That takes several ACTs to different banks of one rank packed inside T_TAW, followed by a query to yet another bank. Directed steps build that pattern, and a long random sweep of inserts and queries with many ACTs to small rank and bank counts reaches it again under overlap with read, write and refresh spacings. A short wait field in the bench also forces refresh spacing into saturation.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [3:0] {
    CMD_ACT  = 4'd0,
    CMD_RD   = 4'd1,
    CMD_RDA  = 4'd2,
    CMD_WR   = 4'd3,
    CMD_WRA  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_PREA = 4'd6,
    CMD_REFA = 4'd7
  } cmd_e;

  // per-bank stamp slots
  localparam int BS_ACT = 0;
  localparam int BS_RD  = 1;
  localparam int BS_WR  = 2;
  localparam int BS_RDA = 3;
  localparam int BS_WRA = 4;
  localparam int BS_PRE = 5;
  localparam int NB_SLOT = 6;

  // per-rank stamp slots
  localparam int KS_ACT  = 0;
  localparam int KS_RDX  = 1;
  localparam int KS_WRX  = 2;
  localparam int KS_RDA  = 3;
  localparam int KS_WRA  = 4;
  localparam int KS_PRE  = 5;
  localparam int KS_PREA = 6;
  localparam int KS_REFA = 7;
  localparam int NK_SLOT = 8;

  // channel-wide stamp slots
  localparam int GS_RDX = 0;
  localparam int GS_WRX = 1;
  localparam int GS_BUS = 2;
  localparam int NG_SLOT = 3;

  function automatic logic bank_slot_hit(input logic [3:0] c, input int s);
    case (s)
      BS_ACT:  return c == CMD_ACT;
      BS_RD:   return c == CMD_RD;
      BS_WR:   return c == CMD_WR;
      BS_RDA:  return c == CMD_RDA;
      BS_WRA:  return c == CMD_WRA;
      BS_PRE:  return c == CMD_PRE;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic rank_slot_hit(input logic [3:0] c, input int s);
    case (s)
      KS_ACT:  return c == CMD_ACT;
      KS_RDX:  return (c == CMD_RD) || (c == CMD_RDA);
      KS_WRX:  return (c == CMD_WR) || (c == CMD_WRA);
      KS_RDA:  return c == CMD_RDA;
      KS_WRA:  return c == CMD_WRA;
      KS_PRE:  return c == CMD_PRE;
      KS_PREA: return c == CMD_PREA;
      KS_REFA: return c == CMD_REFA;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic glb_slot_hit(input logic [3:0] c, input int s);
    case (s)
      GS_RDX:  return (c == CMD_RD) || (c == CMD_RDA);
      GS_WRX:  return (c == CMD_WR) || (c == CMD_WRA);
      GS_BUS:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dct_stamp_store.sv
module dct_stamp_store
  import dct_pkg::*;
#(
  parameter int RANK_BITS = 1,
  parameter int BANK_BITS = 3,
  parameter int CNT_W     = 24
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ins_valid,
  input  logic [3:0]                        ins_cmd,
  input  logic [RANK_BITS-1:0]              ins_rank,
  input  logic [BANK_BITS-1:0]              ins_bank,
  input  logic [RANK_BITS-1:0]              qry_rank,
  input  logic [BANK_BITS-1:0]              qry_bank,
  output logic [CNT_W-1:0]                  now,
  output logic [NB_SLOT-1:0][CNT_W-1:0]     bank_ts,
  output logic [NB_SLOT-1:0]                bank_v,
  output logic [NK_SLOT-1:0][CNT_W-1:0]     rank_ts,
  output logic [NK_SLOT-1:0]                rank_v,
  output logic [NG_SLOT-1:0][CNT_W-1:0]     glb_ts,
  output logic [NG_SLOT-1:0]                glb_v
);
  localparam int IW  = RANK_BITS + BANK_BITS;
  localparam int NRB = 1 << IW;
  localparam int NR  = 1 << RANK_BITS;

  logic [IW-1:0] ins_idx, qry_idx;
  logic          ins_ok;

  assign ins_idx = {ins_rank, ins_bank};
  assign qry_idx = {qry_rank, qry_bank};
  assign ins_ok  = ins_valid && !ins_cmd[3];

  // free-running timestamp source
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

  // per-bank slots: one small RAM per slot, async read, valid bits reset
  for (genvar gs = 0; gs < NB_SLOT; gs++) begin : g_bslot
    logic [CNT_W-1:0] mem [NRB];
    logic [NRB-1:0]   vld;
    logic             hit, fwd;

    assign hit = ins_ok && bank_slot_hit(ins_cmd, gs);
    assign fwd = hit && (ins_idx == qry_idx);

    always_ff @(posedge clk) begin
      if (hit) mem[ins_idx] <= now;
    end

    always_ff @(posedge clk) begin
      if (rst)      vld <= '0;
      else if (hit) vld[ins_idx] <= 1'b1;
    end

    assign bank_ts[gs] = fwd ? now : mem[qry_idx];
    assign bank_v[gs]  = fwd | vld[qry_idx];
  end

  // per-rank slots
  for (genvar gk = 0; gk < NK_SLOT; gk++) begin : g_kslot
    logic [CNT_W-1:0] mem [NR];
    logic [NR-1:0]    vld;
    logic             hit, fwd;

    assign hit = ins_ok && rank_slot_hit(ins_cmd, gk);
    assign fwd = hit && (ins_rank == qry_rank);

    always_ff @(posedge clk) begin
      if (hit) mem[ins_rank] <= now;
    end

    always_ff @(posedge clk) begin
      if (rst)      vld <= '0;
      else if (hit) vld[ins_rank] <= 1'b1;
    end

    assign rank_ts[gk] = fwd ? now : mem[qry_rank];
    assign rank_v[gk]  = fwd | vld[qry_rank];
  end

  // channel-wide slots
  for (genvar gg = 0; gg < NG_SLOT; gg++) begin : g_gslot
    logic [CNT_W-1:0] ts;
    logic             vld;
    logic             hit;

    assign hit = ins_ok && glb_slot_hit(ins_cmd, gg);

    always_ff @(posedge clk) begin
      if (hit) ts <= now;
    end

    always_ff @(posedge clk) begin
      if (rst)      vld <= 1'b0;
      else if (hit) vld <= 1'b1;
    end

    assign glb_ts[gg] = hit ? now : ts;
    assign glb_v[gg]  = hit | vld;
  end

endmodule

// File: rtl/dct_act_window.sv
module dct_act_window #(
  parameter int RANK_BITS = 1,
  parameter int CNT_W     = 24,
  parameter int ACT_WIN   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     now,
  input  logic                 ins_act,
  input  logic [RANK_BITS-1:0] ins_rank,
  input  logic [RANK_BITS-1:0] qry_rank,
  output logic                 win_full,
  output logic [CNT_W-1:0]     win_oldest
);
  localparam int NR = 1 << RANK_BITS;
  localparam int PW = (ACT_WIN > 1) ? $clog2(ACT_WIN) : 1;
  localparam logic [PW:0]   FILL_MAX = (PW+1)'(ACT_WIN);
  localparam logic [PW-1:0] WP_LAST  = PW'(ACT_WIN - 1);

  logic [NR-1:0]            full_r;
  logic [NR-1:0][CNT_W-1:0] old_r;

  for (genvar gr = 0; gr < NR; gr++) begin : g_rank
    logic [CNT_W-1:0] slot [ACT_WIN];
    logic [PW-1:0]    wp, wp_nx;
    logic [PW:0]      fill;
    logic             hit;

    assign hit   = ins_act && (ins_rank == RANK_BITS'(gr));
    assign wp_nx = (wp == WP_LAST) ? '0 : wp + 1'b1;

    // circular buffer of activate stamps; wp points at the oldest once full
    always_ff @(posedge clk) begin
      if (hit) slot[wp] <= now;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp   <= '0;
        fill <= '0;
      end else if (hit) begin
        wp <= wp_nx;
        if (fill != FILL_MAX) fill <= fill + 1'b1;
      end
    end

    // view including an activate inserted this very cycle
    assign full_r[gr] = (fill == FILL_MAX) || (hit && (fill == FILL_MAX - 1'b1));
    assign old_r[gr]  = (hit && (wp_nx == wp)) ? now : slot[hit ? wp_nx : wp];
  end

  assign win_full   = full_r[qry_rank];
  assign win_oldest = old_r[qry_rank];

endmodule

// File: rtl/dct_delay_calc.sv
module dct_delay_calc
  import dct_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int BL    = 4,
  parameter int RL    = 6,
  parameter int WL    = 4,
  parameter int T_RC  = 22,
  parameter int T_RP  = 8,
  parameter int T_RAS = 14,
  parameter int T_WR  = 6,
  parameter int T_WTR = 4,
  parameter int T_RFC = 40,
  parameter int T_TAW = 20
) (
  input  logic [3:0]                    qry_cmd,
  input  logic [CNT_W-1:0]              now,
  input  logic [NB_SLOT-1:0][CNT_W-1:0] bank_ts,
  input  logic [NB_SLOT-1:0]            bank_v,
  input  logic [NK_SLOT-1:0][CNT_W-1:0] rank_ts,
  input  logic [NK_SLOT-1:0]            rank_v,
  input  logic [NG_SLOT-1:0][CNT_W-1:0] glb_ts,
  input  logic [NG_SLOT-1:0]            glb_v,
  input  logic                          win_full,
  input  logic [CNT_W-1:0]              win_oldest,
  output logic [31:0]                   remain
);
  localparam logic [31:0] D_CCD     = 32'(BL);
  localparam logic [31:0] D_RD_PRE  = 32'(BL);
  localparam logic [31:0] D_WR_PRE  = 32'(WL + BL - 1 + T_WR);
  localparam logic [31:0] D_RDA_ACT = 32'(BL + T_RP);
  localparam logic [31:0] D_WRA_ACT = 32'(WL + BL - 1 + T_WR + T_RP);
  localparam logic [31:0] D_WR_RD   = 32'(WL + BL - 1 + T_WTR);
  localparam logic [31:0] D_RD_WR   = 32'(RL + BL + 1);
  localparam logic [31:0] D_RC      = 32'(T_RC);
  localparam logic [31:0] D_RP      = 32'(T_RP);
  localparam logic [31:0] D_RAS     = 32'(T_RAS);
  localparam logic [31:0] D_RFC     = 32'(T_RFC);
  localparam logic [31:0] D_TAW     = 32'(T_TAW);

  // cycles still to wait for one spacing rule; elapsed time is modular
  function automatic logic [31:0] gap(input logic v, input logic [CNT_W-1:0] ts,
                                      input logic [31:0] d, input logic [CNT_W-1:0] nw);
    logic [CNT_W-1:0] el;
    logic [31:0]      el32;
    el   = nw - ts;
    el32 = 32'(el);
    if (v && (d > el32)) return d - el32;
    return 32'd0;
  endfunction

  function automatic logic [31:0] mx(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    remain = gap(glb_v[GS_BUS], glb_ts[GS_BUS], 32'd1, now);
    case (qry_cmd)
      CMD_ACT: begin
        remain = mx(remain, gap(bank_v[BS_ACT], bank_ts[BS_ACT], D_RC, now));
        remain = mx(remain, gap(bank_v[BS_PRE], bank_ts[BS_PRE], D_RP, now));
        remain = mx(remain, gap(rank_v[KS_PREA], rank_ts[KS_PREA], D_RP, now));
        remain = mx(remain, gap(bank_v[BS_RDA], bank_ts[BS_RDA], D_RDA_ACT, now));
        remain = mx(remain, gap(bank_v[BS_WRA], bank_ts[BS_WRA], D_WRA_ACT, now));
        remain = mx(remain, gap(win_full, win_oldest, D_TAW, now));
      end
      CMD_RD, CMD_RDA: begin
        remain = mx(remain, gap(glb_v[GS_RDX], glb_ts[GS_RDX], D_CCD, now));
        remain = mx(remain, gap(glb_v[GS_WRX], glb_ts[GS_WRX], D_WR_RD, now));
      end
      CMD_WR, CMD_WRA: begin
        remain = mx(remain, gap(glb_v[GS_RDX], glb_ts[GS_RDX], D_RD_WR, now));
        remain = mx(remain, gap(glb_v[GS_WRX], glb_ts[GS_WRX], D_CCD, now));
      end
      CMD_PRE: begin
        remain = mx(remain, gap(bank_v[BS_RD], bank_ts[BS_RD], D_RD_PRE, now));
        remain = mx(remain, gap(bank_v[BS_WR], bank_ts[BS_WR], D_WR_PRE, now));
      end
      CMD_PREA: begin
        remain = mx(remain, gap(rank_v[KS_ACT], rank_ts[KS_ACT], D_RAS, now));
        remain = mx(remain, gap(rank_v[KS_RDX], rank_ts[KS_RDX], D_RD_PRE, now));
        remain = mx(remain, gap(rank_v[KS_WRX], rank_ts[KS_WRX], D_WR_PRE, now));
      end
      CMD_REFA: begin
        remain = mx(remain, gap(rank_v[KS_ACT], rank_ts[KS_ACT], D_RC, now));
        remain = mx(remain, gap(rank_v[KS_RDA], rank_ts[KS_RDA], D_RDA_ACT, now));
        remain = mx(remain, gap(rank_v[KS_WRA], rank_ts[KS_WRA], D_WRA_ACT, now));
        remain = mx(remain, gap(rank_v[KS_PRE], rank_ts[KS_PRE], D_RP, now));
        remain = mx(remain, gap(rank_v[KS_PREA], rank_ts[KS_PREA], D_RP, now));
        remain = mx(remain, gap(rank_v[KS_REFA], rank_ts[KS_REFA], D_RFC, now));
      end
      default: remain = 32'd0;
    endcase
  end

endmodule

// File: rtl/dram_cmd_timing_chk.sv
module dram_cmd_timing_chk
  import dct_pkg::*;
#(
  parameter int RANK_BITS = 1,
  parameter int BANK_BITS = 3,
  parameter int CNT_W     = 24,
  parameter int WAIT_W    = 8,
  parameter int ACT_WIN   = 2,
  parameter int BL        = 4,
  parameter int RL        = 6,
  parameter int WL        = 4,
  parameter int T_RC      = 22,
  parameter int T_RP      = 8,
  parameter int T_RAS     = 14,
  parameter int T_WR      = 6,
  parameter int T_WTR     = 4,
  parameter int T_RFC     = 40,
  parameter int T_TAW     = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           qry_cmd,
  input  logic [RANK_BITS-1:0] qry_rank,
  input  logic [BANK_BITS-1:0] qry_bank,
  input  logic                 ins_valid,
  input  logic [3:0]           ins_cmd,
  input  logic [RANK_BITS-1:0] ins_rank,
  input  logic [BANK_BITS-1:0] ins_bank,
  output logic [WAIT_W-1:0]    wait_cnt,
  output logic                 cmd_ready,
  output logic                 cmd_err
);
  localparam logic [31:0] WAIT_MAX = 32'((1 << WAIT_W) - 1);

  logic [CNT_W-1:0]              now;
  logic [NB_SLOT-1:0][CNT_W-1:0] bank_ts;
  logic [NB_SLOT-1:0]            bank_v;
  logic [NK_SLOT-1:0][CNT_W-1:0] rank_ts;
  logic [NK_SLOT-1:0]            rank_v;
  logic [NG_SLOT-1:0][CNT_W-1:0] glb_ts;
  logic [NG_SLOT-1:0]            glb_v;
  logic                          win_full;
  logic [CNT_W-1:0]              win_oldest;
  logic [31:0]                   remain;
  logic                          ins_act;

  assign ins_act = ins_valid && (ins_cmd == CMD_ACT);

  dct_stamp_store #(
    .RANK_BITS(RANK_BITS), .BANK_BITS(BANK_BITS), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_cmd(ins_cmd), .ins_rank(ins_rank), .ins_bank(ins_bank),
    .qry_rank(qry_rank), .qry_bank(qry_bank),
    .now(now),
    .bank_ts(bank_ts), .bank_v(bank_v),
    .rank_ts(rank_ts), .rank_v(rank_v),
    .glb_ts(glb_ts), .glb_v(glb_v)
  );

  dct_act_window #(
    .RANK_BITS(RANK_BITS), .CNT_W(CNT_W), .ACT_WIN(ACT_WIN)
  ) u_window (
    .clk(clk), .rst(rst), .now(now),
    .ins_act(ins_act), .ins_rank(ins_rank), .qry_rank(qry_rank),
    .win_full(win_full), .win_oldest(win_oldest)
  );

  dct_delay_calc #(
    .CNT_W(CNT_W), .BL(BL), .RL(RL), .WL(WL), .T_RC(T_RC), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_WR(T_WR), .T_WTR(T_WTR), .T_RFC(T_RFC), .T_TAW(T_TAW)
  ) u_calc (
    .qry_cmd(qry_cmd), .now(now),
    .bank_ts(bank_ts), .bank_v(bank_v),
    .rank_ts(rank_ts), .rank_v(rank_v),
    .glb_ts(glb_ts), .glb_v(glb_v),
    .win_full(win_full), .win_oldest(win_oldest),
    .remain(remain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt  <= '0;
      cmd_ready <= 1'b0;
      cmd_err   <= 1'b0;
    end else if (qry_cmd[3]) begin
      wait_cnt  <= '0;
      cmd_ready <= 1'b0;
      cmd_err   <= 1'b1;
    end else begin
      wait_cnt  <= (remain > WAIT_MAX) ? WAIT_MAX[WAIT_W-1:0] : remain[WAIT_W-1:0];
      cmd_ready <= (remain == 32'd0);
      cmd_err   <= 1'b0;
    end
  end

endmodule

// File: rtl/dct_timing_chk_sva.sv
module dct_timing_chk_sva #(
  parameter int RANK_BITS = 1,
  parameter int BANK_BITS = 3,
  parameter int WAIT_W    = 8,
  parameter int T_RFC     = 40
) (
  input logic                 clk,
  input logic                 rst,
  input logic [3:0]           qry_cmd,
  input logic [RANK_BITS-1:0] qry_rank,
  input logic [BANK_BITS-1:0] qry_bank,
  input logic                 ins_valid,
  input logic [3:0]           ins_cmd,
  input logic [RANK_BITS-1:0] ins_rank,
  input logic [WAIT_W-1:0]    wait_cnt,
  input logic                 cmd_ready,
  input logic                 cmd_err
);
  localparam int WMAX = (1 << WAIT_W) - 1;
  localparam logic [WAIT_W-1:0] RFC_SAT = (T_RFC > WMAX) ? WAIT_W'(WMAX) : WAIT_W'(T_RFC);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 3)  age <= age + 1'b1;
  end

  assert_ready_means_zero_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (wait_cnt == '0 && !cmd_err));

  assert_illegal_flag_R12: assert property (@(posedge clk) disable iff (rst)
    (age != 0 && $past(qry_cmd[3])) |-> (cmd_err && !cmd_ready && wait_cnt == '0));

  assert_bus_gap_R10: assert property (@(posedge clk) disable iff (rst)
    (age != 0 && $past(ins_valid && !ins_cmd[3] && !qry_cmd[3])) |-> !cmd_ready);

  assert_refresh_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (age != 0 && $past(ins_valid && ins_cmd == 4'd7 && qry_cmd == 4'd7 && ins_rank == qry_rank))
    |-> (wait_cnt == RFC_SAT));

  assert_countdown_R11: assert property (@(posedge clk) disable iff (rst)
    (age == 3 && $past(!ins_valid) && !$past(qry_cmd[3])
     && $past(qry_cmd) == $past(qry_cmd, 2)
     && $past(qry_rank) == $past(qry_rank, 2)
     && $past(qry_bank) == $past(qry_bank, 2)
     && $past(wait_cnt) != '0 && $past(wait_cnt) != WAIT_W'(WMAX))
    |-> (wait_cnt == $past(wait_cnt) - 1'b1));

endmodule

bind dram_cmd_timing_chk dct_timing_chk_sva #(
  .RANK_BITS(RANK_BITS), .BANK_BITS(BANK_BITS), .WAIT_W(WAIT_W), .T_RFC(T_RFC)
) u_sva (
  .clk(clk), .rst(rst), .qry_cmd(qry_cmd), .qry_rank(qry_rank), .qry_bank(qry_bank),
  .ins_valid(ins_valid), .ins_cmd(ins_cmd), .ins_rank(ins_rank),
  .wait_cnt(wait_cnt), .cmd_ready(cmd_ready), .cmd_err(cmd_err)
);

// File: tb/dram_cmd_timing_chk_bench.sv
`timescale 1ns/1ps
module dram_cmd_timing_chk_bench;
  localparam int RB = 1, BB = 2, NR = 2, NBK = 4;
  localparam int BL = 4, RL = 6, WL = 3;
  localparam int TRC = 10, TRP = 3, TRAS = 7, TWR = 4, TWTR = 2, TRFC = 18, TTAW = 8;
  localparam int AW = 2, CW = 16, WW = 4, WMAX = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    qry_cmd = '0;
  logic [RB-1:0] qry_rank = '0;
  logic [BB-1:0] qry_bank = '0;
  logic          ins_valid = 1'b0;
  logic [3:0]    ins_cmd = '0;
  logic [RB-1:0] ins_rank = '0;
  logic [BB-1:0] ins_bank = '0;
  logic [WW-1:0] wait_cnt;
  logic          cmd_ready, cmd_err;

  always #4 clk = ~clk;

  dram_cmd_timing_chk #(
    .RANK_BITS(RB), .BANK_BITS(BB), .CNT_W(CW), .WAIT_W(WW), .ACT_WIN(AW),
    .BL(BL), .RL(RL), .WL(WL), .T_RC(TRC), .T_RP(TRP), .T_RAS(TRAS),
    .T_WR(TWR), .T_WTR(TWTR), .T_RFC(TRFC), .T_TAW(TTAW)
  ) u_dram_cmd_timing_chk (
    .clk(clk), .rst(rst), .qry_cmd(qry_cmd), .qry_rank(qry_rank), .qry_bank(qry_bank),
    .ins_valid(ins_valid), .ins_cmd(ins_cmd), .ins_rank(ins_rank), .ins_bank(ins_bank),
    .wait_cnt(wait_cnt), .cmd_ready(cmd_ready), .cmd_err(cmd_err)
  );

  int checks = 0;
  int errors = 0;
  int tnow = 0;
  bit done = 1'b0;

  // reference state: issue time of each command class, -1 = never
  int bk [6][NR*NBK];   // ACT, RD, WR, RDA, WRA, PRE per bank
  int rk [8][NR];       // ACT, RD|RDA, WR|WRA, RDA, WRA, PRE, PREA, REFA per rank
  int gl [3];           // RD|RDA, WR|WRA, any command
  int acts [NR][AW];    // newest first
  int nacts [NR];

  task automatic model_clear();
    for (int i = 0; i < 6; i++) for (int j = 0; j < NR*NBK; j++) bk[i][j] = -1;
    for (int i = 0; i < 8; i++) for (int j = 0; j < NR; j++) rk[i][j] = -1;
    for (int i = 0; i < 3; i++) gl[i] = -1;
    for (int r = 0; r < NR; r++) begin
      nacts[r] = 0;
      for (int k = 0; k < AW; k++) acts[r][k] = -1;
    end
  endtask

  function automatic int after(int ts, int d, int nw);
    if (ts < 0) return 0;
    return (ts + d > nw) ? ts + d - nw : 0;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic model_insert(int c, int r, int b, int nw);
    int idx;
    idx = r*NBK + b;
    if (c > 7) return;
    gl[2] = nw;
    case (c)
      0: begin
        bk[0][idx] = nw; rk[0][r] = nw;
        for (int k = AW-1; k > 0; k--) acts[r][k] = acts[r][k-1];
        acts[r][0] = nw;
        if (nacts[r] < AW) nacts[r]++;
      end
      1: begin bk[1][idx] = nw; rk[1][r] = nw; gl[0] = nw; end
      2: begin bk[3][idx] = nw; rk[1][r] = nw; rk[3][r] = nw; gl[0] = nw; end
      3: begin bk[2][idx] = nw; rk[2][r] = nw; gl[1] = nw; end
      4: begin bk[4][idx] = nw; rk[2][r] = nw; rk[4][r] = nw; gl[1] = nw; end
      5: begin bk[5][idx] = nw; rk[5][r] = nw; end
      6: rk[6][r] = nw;
      default: rk[7][r] = nw;
    endcase
  endtask

  function automatic int model_wait(int c, int r, int b, int nw);
    int idx, e;
    idx = r*NBK + b;
    if (c > 7) return 0;
    e = after(gl[2], 1, nw);
    case (c)
      0: begin
        e = mx(e, after(bk[0][idx], TRC, nw));
        e = mx(e, after(bk[5][idx], TRP, nw));
        e = mx(e, after(rk[6][r], TRP, nw));
        e = mx(e, after(bk[3][idx], BL+TRP, nw));
        e = mx(e, after(bk[4][idx], WL+BL-1+TWR+TRP, nw));
        if (nacts[r] >= AW) e = mx(e, after(acts[r][AW-1], TTAW, nw));
      end
      1, 2: begin
        e = mx(e, after(gl[0], BL, nw));
        e = mx(e, after(gl[1], WL+BL-1+TWTR, nw));
      end
      3, 4: begin
        e = mx(e, after(gl[0], RL+BL+1, nw));
        e = mx(e, after(gl[1], BL, nw));
      end
      5: begin
        e = mx(e, after(bk[1][idx], BL, nw));
        e = mx(e, after(bk[2][idx], WL+BL-1+TWR, nw));
      end
      6: begin
        e = mx(e, after(rk[0][r], TRAS, nw));
        e = mx(e, after(rk[1][r], BL, nw));
        e = mx(e, after(rk[2][r], WL+BL-1+TWR, nw));
      end
      default: begin
        e = mx(e, after(rk[0][r], TRC, nw));
        e = mx(e, after(rk[3][r], BL+TRP, nw));
        e = mx(e, after(rk[4][r], WL+BL-1+TWR+TRP, nw));
        e = mx(e, after(rk[5][r], TRP, nw));
        e = mx(e, after(rk[6][r], TRP, nw));
        e = mx(e, after(rk[7][r], TRFC, nw));
      end
    endcase
    return e;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0:       return "R2 R3 R4 R10";
      1, 2:    return "R5 R10";
      3, 4:    return "R6 R10";
      5:       return "R7 R10";
      6:       return "R8 R10";
      7:       return "R9 R10";
      default: return "R12";
    endcase
  endfunction

  // one cycle: drive insert and query, compare the registered answer
  task automatic step(bit iv, int ic, int ir, int ib, int qc, int qr, int qb, string tag);
    int e, ew;
    bit er, ee;
    @(negedge clk);
    ins_valid = iv; ins_cmd = 4'(ic); ins_rank = RB'(ir); ins_bank = BB'(ib);
    qry_cmd = 4'(qc); qry_rank = RB'(qr); qry_bank = BB'(qb);
    if (iv) model_insert(ic, ir, ib, tnow);
    e  = model_wait(qc, qr, qb, tnow);
    ew = (qc > 7) ? 0 : ((e > WMAX) ? WMAX : e);
    er = (qc <= 7) && (e == 0);
    ee = (qc > 7);
    @(posedge clk);
    #1;
    checks++;
    if (int'(wait_cnt) != ew || cmd_ready !== er || cmd_err !== ee) begin
      errors++;
      $display("FAIL %s t=%0d q=%0d r%0d b%0d: actual wait=%0d ready=%0b err=%0b expected wait=%0d ready=%0b err=%0b",
               tag, tnow, qc, qr, qb, wait_cnt, cmd_ready, cmd_err, ew, er, ee);
    end
    tnow++;
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: nothing issued yet
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 7, 1, 3, "R1");
    step(0, 0, 0, 0, 4, 1, 2, "R1");
    // R2 R10: ACT seen by a same-cycle query, then countdown (R11)
    step(1, 0, 0, 0, 0, 0, 0, "R2 R10");
    step(0, 0, 0, 0, 0, 0, 0, "R2 R11");
    // R4: second ACT fills the window, third bank must wait on the oldest
    step(1, 0, 0, 1, 0, 0, 2, "R4");
    step(0, 0, 0, 0, 0, 0, 2, "R4");
    step(0, 0, 0, 0, 0, 1, 2, "R4");
    // R5 R6 R7 R8
    step(1, 1, 0, 0, 3, 1, 0, "R6");
    step(1, 3, 0, 1, 1, 1, 3, "R5");
    step(0, 0, 0, 0, 5, 0, 1, "R7");
    step(0, 0, 0, 0, 5, 0, 0, "R7");
    step(0, 0, 0, 0, 6, 0, 0, "R8");
    // R3: auto-precharge reads and writes, then ACT to those banks
    step(1, 2, 1, 2, 0, 1, 2, "R3");
    step(1, 4, 1, 3, 0, 1, 3, "R3");
    // R9 R11: refresh after refresh saturates the short wait field
    step(1, 7, 1, 0, 7, 1, 0, "R9 R11");
    step(0, 0, 0, 0, 7, 1, 0, "R9 R11");
    step(0, 0, 0, 0, 7, 0, 0, "R9");
    // R12: illegal insert occupies nothing, illegal query flags error
    for (int i = 0; i < 25; i++) step(0, 0, 0, 0, 1, 0, 0, "R11");
    step(1, 12, 0, 0, 1, 0, 0, "R12");
    step(0, 0, 0, 0, 13, 0, 0, "R12");
    step(0, 0, 0, 0, 15, 1, 3, "R12");
    // R2: precharge-all then ACT to its rank
    step(1, 6, 1, 0, 0, 1, 1, "R2");
    step(1, 5, 0, 3, 0, 0, 3, "R2");

    // long mixed sweep over all codes, ranks and banks
    for (int i = 0; i < 6000; i++) begin
      bit iv;
      int ic, qc;
      iv = ($urandom_range(0, 2) != 0);
      ic = ($urandom_range(0, 9) == 0) ? $urandom_range(8, 15) : $urandom_range(0, 7);
      if ($urandom_range(0, 2) == 0) ic = 0;
      qc = ($urandom_range(0, 11) == 0) ? $urandom_range(8, 15) : $urandom_range(0, 7);
      step(iv, ic, $urandom_range(0, NR-1), $urandom_range(0, NBK-1),
           qc, $urandom_range(0, NR-1), $urandom_range(0, NBK-1), tag_of(qc));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule